// File: doc/BRIEF.md
# Privilege-Aware Endianness Selector

This block sits beside a load/store unit and decides, for every memory access, whether the data bytes travel in little-endian or big-endian order. The choice depends on three things: the kind of access, the privilege that applies to it, and one endianness control bit per privilege level (machine, supervisor and user). A modify-privilege enable can make explicit loads and stores act as if they ran at a saved previous privilege.

The block also reorders the bytes. Store data is reversed inside the access width before it leaves the block. The block latches the endianness flag and the size of each explicit request, and uses them later to reorder the load data when the response comes back, whatever the control inputs hold by then. Instruction fetches are always little-endian. Page-table walks always follow the supervisor control bit.

Top module: `endsel_top`

## Requirements
- R1: An explicit access (kind code 1) whose effective privilege is machine is big-endian exactly when the machine control bit is 1, and little-endian when that bit is 0.
- R2: An explicit access with effective privilege supervisor follows the supervisor control bit. One with effective privilege user follows the user control bit. Both use the encoding 1 = big-endian.
- R3: When the supervisor level is not built (HAS_SMODE=0), the supervisor control bit counts as 0. When the user level is not built (HAS_UMODE=0), the user control bit counts as 0.
- R4: A fetch (kind code 0) is always little-endian, whatever the control bits hold. The reserved kind code 3 is also little-endian.
- R5: A page-table walk (kind code 2) follows the supervisor control bit, whatever the current privilege and the modify-privilege enable hold.
- R6: When the modify-privilege enable is 1, an explicit access uses the saved previous privilege instead of the current one. Fetches and walks are not affected by the enable.
- R7: When HAS_UMODE=0, the modify-privilege enable has no effect, and explicit accesses use the current privilege.
- R8: Size code s selects an access of 2^s bytes (codes 0 to 3 give 1, 2, 4 and 8 bytes). For a big-endian access, output byte k is taken from input byte 2^s-1-k inside the width. For a little-endian access, output byte k is input byte k. Output bytes above the width are 0, so a single-byte access passes its low byte through unchanged.
- R9: Load response data is reordered using the big-endian flag and the size latched at the most recent explicit request. After reset, the latched values are little-endian and 1 byte.
- R10: The privilege is encoded as 0 = user, 1 = supervisor, 3 = machine. The value 2 is treated as user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_prv | input | 2 | Current privilege level |
| mprv_en | input | 1 | Modify-privilege enable |
| mprv_prv | input | 2 | Saved previous privilege |
| m_big | input | 1 | Machine-level endianness control |
| s_big | input | 1 | Supervisor-level endianness control |
| u_big | input | 1 | User-level endianness control |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 0 fetch, 1 explicit, 2 page-table walk, 3 reserved |
| req_size | input | 2 | Access size code, 2^code bytes |
| st_data | input | XLEN | Store data, in register order |
| req_big | output | 1 | Effective big-endian flag for the request |
| st_data_out | output | XLEN | Store data in memory byte order |
| ld_valid | input | 1 | Load response present |
| ld_data | input | XLEN | Load data in memory byte order |
| ld_data_out | output | XLEN | Load data in register order |

## Verification
The bench builds two copies of the block and drives both with the same inputs. The first copy uses the defaults (XLEN=64, with both the supervisor and the user levels built), so all four sizes, every privilege, the modify-privilege override and the load latch can be reached. The second copy is built with HAS_SMODE=0 and HAS_UMODE=0. Only this copy can show that the lower-level control bits are forced to zero and that the modify-privilege enable is ignored.

// File: rtl/endsel_pkg.sv
package endsel_pkg;
    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } prv_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_DATA  = 2'd1,
        ACC_WALK  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // state latched at each explicit request, consumed by the load return path
    typedef struct packed {
        logic       big;
        logic [1:0] size;
    } lat_t;
endpackage

// File: rtl/endsel_mode.sv
module endsel_mode
    import endsel_pkg::*;
#(
    parameter bit HAS_SMODE = 1'b1,
    parameter bit HAS_UMODE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cur_prv,
    input  logic       mprv_en,
    input  logic [1:0] mprv_prv,
    input  logic       m_big,
    input  logic       s_big,
    input  logic       u_big,
    input  logic [1:0] kind,
    output logic       big
);
    logic       s_big_eff;
    logic       u_big_eff;
    logic       mprv_eff;
    logic [1:0] eff_prv;

    always_comb begin
        s_big_eff = HAS_SMODE ? s_big : 1'b0;
        u_big_eff = HAS_UMODE ? u_big : 1'b0;
        mprv_eff  = HAS_UMODE ? mprv_en : 1'b0;
        // only explicit data accesses take the override
        eff_prv   = (kind == ACC_DATA && mprv_eff) ? mprv_prv : cur_prv;
        unique case (acc_e'(kind))
            ACC_WALK: big = s_big_eff;
            ACC_DATA: begin
                unique case (prv_e'(eff_prv))
                    PRV_MACH:  big = m_big;
                    PRV_SUPER: big = s_big_eff;
                    default:   big = u_big_eff;
                endcase
            end
            default:  big = 1'b0;
        endcase
    end

    // R4: fetch and reserved kinds never go big-endian
    a_r4_fetch_little: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_FETCH || kind == ACC_RSVD) |-> !big);

    // R5: walks track the supervisor bit
    a_r5_walk_follows_s: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WALK && HAS_SMODE) |-> (big == s_big));

    generate
        if (!HAS_SMODE) begin : g_no_s
            // R3: no supervisor level, walks are little-endian
            a_r3_walk_no_s: assert property (@(posedge clk) disable iff (!rst_n)
                (kind == ACC_WALK) |-> !big);
        end
        if (!HAS_UMODE) begin : g_no_u
            // R7: override ignored, machine data accesses follow the machine bit
            a_r7_mprv_dead: assert property (@(posedge clk) disable iff (!rst_n)
                (kind == ACC_DATA && cur_prv == PRV_MACH) |-> (big == m_big));
        end
    endgenerate
endmodule

// File: rtl/endsel_swap.sv
module endsel_swap #(
    parameter int NBYTES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NBYTES*8-1:0] din,
    input  logic [1:0]          size,
    input  logic                big,
    output logic [NBYTES*8-1:0] dout
);
    localparam int MAXSZ = $clog2(NBYTES);

    int width;

    always_comb begin
        width = 1 << ((int'(size) > MAXSZ) ? MAXSZ : int'(size));
        dout  = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (k < width) begin
                if (big) dout[k*8 +: 8] = din[(width-1-k)*8 +: 8];
                else     dout[k*8 +: 8] = din[k*8 +: 8];
            end
        end
    end

    // R8: a single byte passes through untouched, upper bytes cleared
    a_r8_byte_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'd0) |-> (dout == {{(NBYTES-1)*8{1'b0}}, din[7:0]}));
endmodule

// File: rtl/endsel_top.sv
module endsel_top
    import endsel_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter bit HAS_SMODE = 1'b1,
    parameter bit HAS_UMODE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cur_prv,
    input  logic            mprv_en,
    input  logic [1:0]      mprv_prv,
    input  logic            m_big,
    input  logic            s_big,
    input  logic            u_big,
    input  logic            req_valid,
    input  logic [1:0]      req_kind,
    input  logic [1:0]      req_size,
    input  logic [XLEN-1:0] st_data,
    output logic            req_big,
    output logic [XLEN-1:0] st_data_out,
    input  logic            ld_valid,
    input  logic [XLEN-1:0] ld_data,
    output logic [XLEN-1:0] ld_data_out
);
    localparam int NBYTES = XLEN / 8;

    lat_t lat_d, lat_q;
    logic [XLEN-1:0] ld_sw;

    endsel_mode #(.HAS_SMODE(HAS_SMODE), .HAS_UMODE(HAS_UMODE)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_prv  (cur_prv),
        .mprv_en  (mprv_en),
        .mprv_prv (mprv_prv),
        .m_big    (m_big),
        .s_big    (s_big),
        .u_big    (u_big),
        .kind     (req_kind),
        .big      (req_big)
    );

    endsel_swap #(.NBYTES(NBYTES)) u_st_swap (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (st_data),
        .size  (req_size),
        .big   (req_big),
        .dout  (st_data_out)
    );

    endsel_swap #(.NBYTES(NBYTES)) u_ld_swap (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ld_data),
        .size  (lat_q.size),
        .big   (lat_q.big),
        .dout  (ld_sw)
    );

    always_comb begin
        lat_d = lat_q;
        if (req_valid && req_kind == ACC_DATA) begin
            lat_d.big  = req_big;
            lat_d.size = req_size;
        end
        ld_data_out = ld_valid ? ld_sw : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    // R9: latch only moves on an explicit request
    a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_kind == ACC_DATA) |=> $stable(lat_q));

    // R9: latched flag matches the flag shown with the request
    a_r9_latch_take: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == ACC_DATA) |=> (lat_q.big == $past(req_big)));
endmodule

// File: tb/tb_endsel_top.sv
module tb_endsel_top;
    localparam int XLEN = 64;

    typedef struct {
        int          inst;
        bit          is_ld;
        bit          exp_big;
        logic [63:0] exp_data;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cur_prv = '0, mprv_prv = '0, req_kind = '0, req_size = '0;
    logic mprv_en = 0, m_big = 0, s_big = 0, u_big = 0, req_valid = 0, ld_valid = 0;
    logic [XLEN-1:0] st_data = '0, ld_data = '0;
    logic req_big_a, req_big_b;
    logic [XLEN-1:0] st_out_a, st_out_b, ld_out_a, ld_out_b;

    item_t sbq[$];
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    endsel_top #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .cur_prv(cur_prv), .mprv_en(mprv_en), .mprv_prv(mprv_prv),
        .m_big(m_big), .s_big(s_big), .u_big(u_big), .req_valid(req_valid), .req_kind(req_kind),
        .req_size(req_size), .st_data(st_data), .req_big(req_big_a), .st_data_out(st_out_a),
        .ld_valid(ld_valid), .ld_data(ld_data), .ld_data_out(ld_out_a));

    endsel_top #(.XLEN(XLEN), .HAS_SMODE(1'b0), .HAS_UMODE(1'b0)) dut_min (
        .clk(clk), .rst_n(rst_n), .cur_prv(cur_prv), .mprv_en(mprv_en), .mprv_prv(mprv_prv),
        .m_big(m_big), .s_big(s_big), .u_big(u_big), .req_valid(req_valid), .req_kind(req_kind),
        .req_size(req_size), .st_data(st_data), .req_big(req_big_b), .st_data_out(st_out_b),
        .ld_valid(ld_valid), .ld_data(ld_data), .ld_data_out(ld_out_b));

    function automatic bit ref_big(bit hs, bit hu, logic [1:0] prv, bit mp, logic [1:0] mpp,
                                   bit mb, bit sb, bit ub, logic [1:0] kind);
        logic [1:0] p;
        p = (kind == 2'd1 && hu && mp) ? mpp : prv;
        if (kind == 2'd0 || kind == 2'd3) return 1'b0;
        if (kind == 2'd2) return hs & sb;
        if (p == 2'd3) return mb;
        if (p == 2'd1) return hs & sb;
        return hu & ub;
    endfunction

    function automatic logic [63:0] ref_swap(logic [63:0] d, logic [1:0] size, bit big);
        logic [63:0] r;
        int n;
        r = '0;
        n = 1 << size;
        for (int k = 0; k < n; k++)
            r[k*8 +: 8] = big ? d[(n-1-k)*8 +: 8] : d[k*8 +: 8];
        return r;
    endfunction

    task automatic drive_req(int inst, logic [1:0] prv, bit mp, logic [1:0] mpp, bit mb, bit sb,
                             bit ub, logic [1:0] kind, logic [1:0] size, logic [63:0] d, string tag);
        item_t it;
        bit hs, hu, b;
        hs = (inst == 0); hu = (inst == 0);
        cur_prv = prv; mprv_en = mp; mprv_prv = mpp; m_big = mb; s_big = sb; u_big = ub;
        req_valid = 1'b1; req_kind = kind; req_size = size; st_data = d; ld_valid = 1'b0;
        b = ref_big(hs, hu, prv, mp, mpp, mb, sb, ub, kind);
        it.inst = inst; it.is_ld = 1'b0; it.exp_big = b; it.exp_data = ref_swap(d, size, b); it.tag = tag;
        sbq.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic drive_ld(logic [63:0] d, bit lbig, logic [1:0] lsize, string tag);
        item_t it;
        req_valid = 1'b0; ld_valid = 1'b1; ld_data = d;
        // scramble controls: the return path must not look at them
        m_big = ~lbig; s_big = ~lbig; u_big = ~lbig; req_size = ~lsize;
        it.inst = 0; it.is_ld = 1'b1; it.exp_big = lbig; it.exp_data = ref_swap(d, lsize, lbig); it.tag = tag;
        sbq.push_back(it);
        @(posedge clk); #1;
        ld_valid = 1'b0;
    endtask

    // monitor: compares away from the active edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            item_t it;
            logic [63:0] act;
            logic act_b;
            it = sbq.pop_front();
            if (it.is_ld) begin
                act = ld_out_a;
                checks++;
                if (act !== it.exp_data) begin
                    fails++;
                    $display("FAIL %s ld_data_out act=%h exp=%h", it.tag, act, it.exp_data);
                end
            end else begin
                act   = (it.inst == 0) ? st_out_a : st_out_b;
                act_b = (it.inst == 0) ? req_big_a : req_big_b;
                checks++;
                if (act_b !== it.exp_big) begin
                    fails++;
                    $display("FAIL %s req_big act=%b exp=%b", it.tag, act_b, it.exp_big);
                end
                checks++;
                if (act !== it.exp_data) begin
                    fails++;
                    $display("FAIL %s st_data_out act=%h exp=%h", it.tag, act, it.exp_data);
                end
            end
        end
    end

    localparam logic [63:0] PAT = 64'h1122334455667788;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R9: reset latch is little-endian, one byte
        drive_ld(PAT, 1'b0, 2'd0, "R9 reset latch");
        // R1 machine bit
        drive_req(0, 2'd3, 0, 2'd0, 1, 0, 0, 2'd1, 2'd3, PAT, "R1 M big 8B");
        drive_req(0, 2'd3, 0, 2'd0, 0, 1, 1, 2'd1, 2'd3, PAT, "R1 M little");
        // R2 supervisor and user bits
        drive_req(0, 2'd1, 0, 2'd0, 0, 1, 0, 2'd1, 2'd2, PAT, "R2 S big 4B");
        drive_req(0, 2'd0, 0, 2'd0, 1, 1, 0, 2'd1, 2'd2, PAT, "R2 U little");
        drive_req(0, 2'd0, 0, 2'd0, 0, 0, 1, 2'd1, 2'd1, PAT, "R2 U big 2B");
        // R10 privilege 2 acts as user
        drive_req(0, 2'd2, 0, 2'd0, 1, 1, 0, 2'd1, 2'd3, PAT, "R10 prv2 as U little");
        drive_req(0, 2'd2, 0, 2'd0, 0, 0, 1, 2'd1, 2'd3, PAT, "R10 prv2 as U big");
        // R4 fetch and reserved kinds
        drive_req(0, 2'd3, 1, 2'd3, 1, 1, 1, 2'd0, 2'd2, PAT, "R4 fetch little");
        drive_req(0, 2'd0, 0, 2'd0, 1, 1, 1, 2'd3, 2'd3, PAT, "R4 reserved kind");
        // R5 walks follow supervisor bit
        drive_req(0, 2'd0, 0, 2'd0, 0, 1, 0, 2'd2, 2'd3, PAT, "R5 walk from U");
        drive_req(0, 2'd3, 1, 2'd0, 1, 0, 1, 2'd2, 2'd3, PAT, "R5 walk with mprv");
        // R6 override
        drive_req(0, 2'd3, 1, 2'd0, 0, 0, 1, 2'd1, 2'd3, PAT, "R6 mprv to U");
        drive_req(0, 2'd3, 1, 2'd1, 1, 0, 1, 2'd1, 2'd3, PAT, "R6 mprv to S");
        drive_req(0, 2'd3, 1, 2'd0, 0, 1, 1, 2'd0, 2'd3, PAT, "R6 fetch unaffected");
        // R8 sizes
        drive_req(0, 2'd3, 0, 2'd0, 1, 0, 0, 2'd1, 2'd0, PAT, "R8 single byte");
        drive_req(0, 2'd3, 0, 2'd0, 1, 0, 0, 2'd1, 2'd1, 64'hA5A5_0000_0000_BEEF, "R8 2B swap");
        drive_req(0, 2'd3, 0, 2'd0, 0, 0, 0, 2'd1, 2'd2, PAT, "R8 4B little clear");
        // R9 latched flag on return
        drive_req(0, 2'd1, 0, 2'd0, 0, 1, 0, 2'd1, 2'd2, PAT, "R9 load req");
        drive_ld(64'hCAFE_F00D_0102_0304, 1'b1, 2'd2, "R9 load return latched");
        drive_req(0, 2'd0, 0, 2'd0, 1, 1, 1, 2'd0, 2'd3, PAT, "R9 fetch no relatch");
        drive_ld(64'h0807_0605_0403_0201, 1'b1, 2'd2, "R9 latch held over fetch");
        // R3 and R7 on the reduced build
        drive_req(1, 2'd0, 0, 2'd0, 0, 1, 1, 2'd2, 2'd3, PAT, "R3 walk no S");
        drive_req(1, 2'd0, 0, 2'd0, 1, 1, 1, 2'd1, 2'd3, PAT, "R3 U bit dead");
        drive_req(1, 2'd3, 1, 2'd0, 0, 1, 1, 2'd1, 2'd3, PAT, "R7 mprv ignored");
        drive_req(1, 2'd3, 1, 2'd0, 1, 0, 0, 2'd1, 2'd3, PAT, "R7 M bit kept");
        req_valid = 1'b0;
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule